// File: doc/BRIEF.md
# Two-Cycle Memory Bus Master

This block turns single read and write requests into timed cycles on a parallel memory bus. Each request carries a direction, a 16-bit address and, for writes, one data byte. It drives an address bus, a data output with a separate output enable that stands in for a three-state pad, and active-low read and write strobes. It also drives four active-low chip selects, decoded from the top address nibble.

A transfer has two bus cycles. In the first, the address and chip select settle. In the second, the strobe is active. Read data is taken on the falling clock edge in the middle of the second cycle, so a device has half a clock after the strobe falls to present its byte. A third cycle returns a one-cycle acknowledge, with the captured byte for reads. In that cycle the write strobe is already released while the address and data are still held, so a device latching on the strobe's rising transition sees stable values.

Top module: `dpbm_bus_master`

## Requirements
- R1: After reset and whenever no transfer is in progress, `rd_n` and `wr_n` are 1, all `cs_n` bits are 1, `bus_oe` is 0 and `req_ack` is 0.
- R2: A request is taken only at a rising edge where the block is idle and `req_valid` is 1. Requests presented while a transfer is in progress do not change `bus_addr`, `bus_dout` or the strobes of that transfer.
- R3: `bus_addr` carries the request address from the first rising edge after the request is taken (cycle 1).
- R4: For a read (`req_write`=0), `rd_n` is 0 only in cycle 2 and `bus_oe` stays 0 for the whole transfer.
- R5: `rsp_rdata` returned with the acknowledge equals the value of `bus_din` at the falling clock edge in the middle of cycle 2. Changes of `bus_din` before or after that edge have no effect.
- R6: For a write (`req_write`=1), `wr_n` is 0 and `bus_oe` is 1 from the start of cycle 2, with `bus_dout` equal to the request byte (`bus_dout[0]` is D0, the LSB). In cycle 3, `wr_n` is 1 while `bus_oe`, `bus_dout` and `bus_addr` are unchanged.
- R7: `req_ack` is 1 for exactly one cycle, cycle 3, directly after the strobe cycle. The next cycle is idle.
- R8: During cycles 1 to 3, `cs_n[i]` is 0 exactly when `bus_addr[15:12]` equals region tag i. The default tags are 0x0, 0x1, 0x8 and 0xF for i = 0 to 3, so 0x1000 to 0x1FFF selects `cs_n[1]`, and addresses such as 0x5555 select no device.
- R9: The reset input is synchronous and active high. Asserting it during a transfer returns the bus to the idle state of R1 at the next edge, with no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus cycles start on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured by a read, valid with `req_ack` |
| bus_addr | output | 16 | Address bus |
| bus_dout | output | 8 | Data bus, outgoing value |
| bus_oe | output | 1 | Data bus output enable (0 = high impedance) |
| bus_din | input | 8 | Data bus, incoming value |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| cs_n | output | 4 | Chip selects, active low, one per region |

## Verification
The bench issues writes and read-backs to every decoded region, including both ends of one region's range, unmapped nibbles, and bytes that exercise D0 and D7 separately. Mapped and unmapped addresses show whether the decoder matches the exact nibble. During every read strobe cycle the bench presents the correct byte before the falling edge and its inverse just after it. A capture on the wrong edge therefore returns the inverted byte. While a transfer is in progress the bench presents changing requests with `req_valid` held high, which shows whether anything is taken outside idle. Gaps of idle cycles between requests and one reset in the middle of a read show that the block returns to a quiet bus.

// File: rtl/dpbm_pkg.sv
package dpbm_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int SEL_W    = 4;
    localparam int N_REGION = 4;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ADDR   = 2'd1,
        PH_STROBE = 2'd2,
        PH_DONE   = 2'd3
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } xfer_t;

    function automatic phase_e next_phase(input phase_e cur, input logic take);
        phase_e nxt;
        case (cur)
            PH_IDLE:   nxt = take ? PH_ADDR : PH_IDLE;
            PH_ADDR:   nxt = PH_STROBE;
            PH_STROBE: nxt = PH_DONE;
            default:   nxt = PH_IDLE;
        endcase
        return nxt;
    endfunction

    function automatic logic [SEL_W-1:0] region_bits(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: SEL_W];
    endfunction

endpackage

// File: rtl/dpbm_sequencer.sv
module dpbm_sequencer
    import dpbm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  xfer_t  req_in,
    output phase_e phase,
    output xfer_t  held
);

    logic take;
    assign take = (phase == PH_IDLE) && req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            held  <= '0;
        end else begin
            phase <= next_phase(phase, req_valid);
            if (take) begin
                held <= req_in;
            end
        end
    end

    // R2
    accept_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ADDR) |-> ($past(phase) == PH_IDLE && $past(req_valid)));

    // R2
    held_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(held));

endmodule

// File: rtl/dpbm_region_decode.sv
module dpbm_region_decode #(
    parameter int                 N_SEL = 4,
    parameter int                 TAG_W = 4,
    parameter logic [N_SEL*TAG_W-1:0] TAGS = '0
) (
    input  logic             enable,
    input  logic [TAG_W-1:0] sel,
    output logic [N_SEL-1:0] cs_n
);

    for (genvar g = 0; g < N_SEL; g++) begin : g_region
        assign cs_n[g] = !(enable && (sel == TAGS[g*TAG_W +: TAG_W]));
    end

endmodule

// File: rtl/dpbm_read_capture.sv
module dpbm_read_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sample,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    // Mid-cycle capture: the falling edge lands half a clock into the strobe cycle.
    always_ff @(negedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (sample) begin
            q <= din;
        end
    end

endmodule

// File: rtl/dpbm_bus_master.sv
module dpbm_bus_master
    import dpbm_pkg::*;
#(
    parameter logic [N_REGION*SEL_W-1:0] REGION_TAGS = {4'hF, 4'h8, 4'h1, 4'h0}
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ack,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_dout,
    output logic                bus_oe,
    input  logic [DATA_W-1:0]   bus_din,
    output logic                rd_n,
    output logic                wr_n,
    output logic [N_REGION-1:0] cs_n
);

    xfer_t  req_in;
    xfer_t  held;
    phase_e phase;
    logic   busy;
    logic   strobe_cyc;

    assign req_in.wr   = req_write;
    assign req_in.addr = req_addr;
    assign req_in.data = req_wdata;

    dpbm_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .phase     (phase),
        .held      (held)
    );

    assign busy       = (phase != PH_IDLE);
    assign strobe_cyc = (phase == PH_STROBE);

    assign bus_addr = held.addr;
    assign bus_dout = held.data;
    assign rd_n     = !(strobe_cyc && !held.wr);
    assign wr_n     = !(strobe_cyc && held.wr);
    assign bus_oe   = held.wr && (strobe_cyc || phase == PH_DONE);
    assign req_ack  = (phase == PH_DONE);

    dpbm_region_decode #(
        .N_SEL (N_REGION),
        .TAG_W (SEL_W),
        .TAGS  (REGION_TAGS)
    ) u_dec (
        .enable (busy),
        .sel    (region_bits(held.addr)),
        .cs_n   (cs_n)
    );

    dpbm_read_capture #(
        .W (DATA_W)
    ) u_cap (
        .clk    (clk),
        .rst    (rst),
        .sample (strobe_cyc && !held.wr),
        .din    (bus_din),
        .q      (rsp_rdata)
    );

    // R7
    ack_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> $past(!rd_n || !wr_n));

    // R7
    ack_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

    // R6
    wr_release_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> (bus_oe && $stable(bus_addr) && $stable(bus_dout)));

    // R4
    read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> (!bus_oe && wr_n));

    // R8
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R1
    quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (&cs_n) |-> (rd_n && wr_n) || (region_bits(bus_addr) != REGION_TAGS[3:0]
                                        && region_bits(bus_addr) != REGION_TAGS[7:4]
                                        && region_bits(bus_addr) != REGION_TAGS[11:8]
                                        && region_bits(bus_addr) != REGION_TAGS[15:12]));

endmodule

// File: tb/dpbm_bus_master_tb.sv
module dpbm_bus_master_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_write;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ack;
    logic [7:0]  rsp_rdata;
    logic [15:0] bus_addr;
    logic [7:0]  bus_dout;
    logic        bus_oe;
    logic [7:0]  bus_din;
    logic        rd_n;
    logic        wr_n;
    logic [3:0]  cs_n;

    always #5 clk = ~clk;

    dpbm_bus_master dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ack   (req_ack),
        .rsp_rdata (rsp_rdata),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .bus_oe    (bus_oe),
        .bus_din   (bus_din),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .cs_n      (cs_n)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] mem [int];

    localparam int NREQ = 15;
    logic [15:0] t_addr [NREQ];
    logic        t_wr   [NREQ];
    logic [7:0]  t_data [NREQ];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_cs(input logic [15:0] a);
        logic [3:0] r;
        r = 4'hF;
        if (a[15:12] == 4'h0) r[0] = 1'b0;
        if (a[15:12] == 4'h1) r[1] = 1'b0;
        if (a[15:12] == 4'h8) r[2] = 1'b0;
        if (a[15:12] == 4'hF) r[3] = 1'b0;
        return r;
    endfunction

    function automatic logic [7:0] mem_read(input logic [15:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ a[15:8] ^ 8'h96;
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        int          ph;
        int          idx;
        int          gap;
        int          cyc;
        int          tail;
        bit          reset_pending;
        bit          mid_reset;
        bit          done;
        logic [15:0] m_addr;
        logic        m_wr;
        logic [7:0]  m_data;
        logic [7:0]  exp_rd;
        string       t;

        t_addr[0]  = 16'h0010; t_wr[0]  = 1; t_data[0]  = 8'h3C;
        t_addr[1]  = 16'h0010; t_wr[1]  = 0; t_data[1]  = 8'h00;
        t_addr[2]  = 16'h1FFF; t_wr[2]  = 1; t_data[2]  = 8'hA5;
        t_addr[3]  = 16'h1000; t_wr[3]  = 0; t_data[3]  = 8'h00;
        t_addr[4]  = 16'h1FFF; t_wr[4]  = 0; t_data[4]  = 8'h00;
        t_addr[5]  = 16'h8123; t_wr[5]  = 1; t_data[5]  = 8'h81;
        t_addr[6]  = 16'h8123; t_wr[6]  = 0; t_data[6]  = 8'h00;
        t_addr[7]  = 16'h5555; t_wr[7]  = 1; t_data[7]  = 8'h7E;
        t_addr[8]  = 16'h5555; t_wr[8]  = 0; t_data[8]  = 8'h00;
        t_addr[9]  = 16'hF00F; t_wr[9]  = 0; t_data[9]  = 8'h00;
        t_addr[10] = 16'hFFFF; t_wr[10] = 1; t_data[10] = 8'h01;
        t_addr[11] = 16'hFFFF; t_wr[11] = 0; t_data[11] = 8'h00;
        t_addr[12] = 16'h0FFF; t_wr[12] = 0; t_data[12] = 8'h00;
        t_addr[13] = 16'h2000; t_wr[13] = 1; t_data[13] = 8'hC3;
        t_addr[14] = 16'h5555; t_wr[14] = 0; t_data[14] = 8'h00;

        rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        bus_din = 8'h5A;
        ph = 0; idx = 0; gap = 0; cyc = 0; tail = 0;
        reset_pending = 0; mid_reset = 0; done = 0;
        m_addr = '0; m_wr = 0; m_data = '0; exp_rd = '0;

        while (!done) begin
            @(posedge clk);
            // reference model advances on the edge with the inputs held there
            if (rst) begin
                ph = 0;
            end else begin
                case (ph)
                    0: if (req_valid) begin
                           ph = 1; m_addr = req_addr; m_wr = req_write; m_data = req_wdata;
                       end
                    1: ph = 2;
                    2: ph = 3;
                    default: ph = 0;
                endcase
            end
            #2;
            case (ph)
                0: begin
                    t = mid_reset ? "R9" : "R1";
                    chk(t, "rd_n idle", rd_n, 1);
                    chk(t, "wr_n idle", wr_n, 1);
                    chk(t, "cs_n idle", cs_n, 4'hF);
                    chk(t, "bus_oe idle", bus_oe, 0);
                    chk(t, "req_ack idle", req_ack, 0);
                    mid_reset = 0;
                end
                1: begin
                    chk("R3", "bus_addr cycle1", bus_addr, m_addr);
                    chk("R8", "cs_n cycle1", cs_n, exp_cs(m_addr));
                    chk("R4", "rd_n cycle1", rd_n, 1);
                    chk("R6", "wr_n cycle1", wr_n, 1);
                    chk("R4", "bus_oe cycle1", bus_oe, 0);
                    chk("R7", "req_ack cycle1", req_ack, 0);
                end
                2: begin
                    chk("R2", "bus_addr cycle2", bus_addr, m_addr);
                    chk("R8", "cs_n cycle2", cs_n, exp_cs(m_addr));
                    chk("R4", "rd_n cycle2", rd_n, m_wr ? 1 : 0);
                    chk("R6", "wr_n cycle2", wr_n, m_wr ? 0 : 1);
                    chk(m_wr ? "R6" : "R4", "bus_oe cycle2", bus_oe, m_wr);
                    if (m_wr) chk("R6", "bus_dout cycle2", bus_dout, m_data);
                    chk("R7", "req_ack cycle2", req_ack, 0);
                end
                default: begin
                    chk("R2", "bus_addr cycle3", bus_addr, m_addr);
                    chk("R8", "cs_n cycle3", cs_n, exp_cs(m_addr));
                    chk("R4", "rd_n cycle3", rd_n, 1);
                    chk("R6", "wr_n cycle3", wr_n, 1);
                    chk(m_wr ? "R6" : "R4", "bus_oe cycle3", bus_oe, m_wr);
                    chk("R7", "req_ack cycle3", req_ack, 1);
                    if (m_wr) begin
                        chk("R6", "bus_dout cycle3", bus_dout, m_data);
                        mem[int'(m_addr)] = m_data;
                    end else begin
                        chk("R5", "rsp_rdata", rsp_rdata, exp_rd);
                    end
                end
            endcase

            // reset control
            if (cyc < 3) begin
                rst = 1;
            end else if (reset_pending && ph == 2) begin
                rst = 1; reset_pending = 0; mid_reset = 1;
            end else begin
                rst = 0;
            end

            // device side of the data bus
            if (ph == 2 && !m_wr) begin
                exp_rd  = mem_read(m_addr);
                bus_din = exp_rd;
            end else begin
                bus_din = 8'h5A ^ 8'(cyc);
            end

            // requester
            if (ph == 0) begin
                if (cyc < 3 || rst) begin
                    req_valid = 0;
                end else if (gap > 0) begin
                    req_valid = 0; gap--;
                end else if (idx < NREQ) begin
                    req_valid = 1;
                    req_write = t_wr[idx];
                    req_addr  = t_addr[idx];
                    req_wdata = t_data[idx];
                    if (idx == 8) reset_pending = 1;
                    idx++;
                    gap = idx % 3;
                end else begin
                    req_valid = 0;
                    tail++;
                    if (tail > 4) done = 1;
                end
            end else begin
                // competing requests while busy must be ignored (R2)
                req_valid = 1;
                req_write = cyc[0];
                req_addr  = 16'(cyc * 16'h3B1D);
                req_wdata = 8'(cyc * 7);
            end

            cyc++;
            #5;
            bus_din = ~bus_din;
        end
        summary();
    end

endmodule